// File: doc/BRIEF.md
# MDIO Management Master

This block runs management transactions from a station towards PHY devices over a two-wire serial management bus. Software sees two 32-bit registers: a command register and a data register. Software first writes the data register. It then writes the command register with the start flag set. The block then shifts out one complete frame, or two frames in extended-addressing mode, on the management clock and data lines. When the transaction ends, the block clears the busy flag.

Two addressing modes are supported. Short mode carries a 5-bit register number. Extended mode carries a 5-bit device number, followed by a 16-bit register address taken from the upper half of the data register. In extended mode the block first sends an address frame and then the data frame. Read results are placed in the lower half of the data register. The management clock rate is set by a clock-range field, which scales the length of each clock half period.

Top module: `mdio_mgmt`

## Requirements
- R1: Command bit 0 is the busy/start flag. A command write with bit 0 set while idle reads back busy from the next cycle. Busy drops in the cycle where the last frame bit period ends, which is 64 bit periods after the start in short mode and 128 in extended mode.
- R2: In short mode (command bit 1 clear), the frame is sent MSB first and contains: 32 ones, start 01, opcode (01 write, 10 read), PHY address (command bits 20:16), register number (command bits 12:8), turnaround 10, and data register bits 15:0. Each bit is presented from one falling management clock edge to the next.
- R3: In extended mode (command bit 1 set), the block first sends an address frame and then a second frame. The address frame contains 32 ones, 00, 00, PHY address, device number (command bits 12:8), 10, and data register bits 31:16. The second frame contains 32 ones, 00, opcode (01 write, 11 read), PHY address, device number, 10, and data register bits 15:0.
- R4: The management clock half period is (CR+1)*STEP system cycles, where CR is command bits 6:4. Each bit starts with the low half. The clock toggles only while busy and stays low when idle.
- R5: In a read, the data output enable is released for the two turnaround bits and the 16 data bits of the last frame. Data is sampled MSB first on rising management clock edges. It lands in data register bits 15:0, and bits 31:16 keep their value. Outside a transaction the enable is low.
- R6: Command bits 3:2 hold the operation. Bit 3 alone picks read (1) or write (0), so code 11 or 10 reads and code 01 or 00 writes.
- R7: While busy, writes to either register are ignored and do not start a new transaction.
- R8: Reset clears both registers. A command write with bit 0 clear only stores the fields, and no clock toggles. The command register reads back bits 20:16, 12:8 and 6:0, with all other bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 command, 1 data |
| wr_data | input | 32 | Register write value |
| rd_sel | input | 1 | Readback select: 0 command, 1 data |
| rd_data | output | 32 | Selected register value |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Management data from the pad |
| mdio_o | output | 1 | Management data towards the pad |
| mdio_oe | output | 1 | Output enable for the data pad |

## Verification
The checks assume that the PHY side only reads mdio_i while the enable is low. They also assume software accepts that a register write arriving while busy is lost. The stimulus drives the responder only during released bit periods and holds mdio_i high otherwise. Writes that arrive while busy are issued on purpose, so that the ignore rule is exercised while the frame continues to be compared bit by bit. Readback is done only between transactions, because the per-clock check reads busy through the same port.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_BITS = 64;
    localparam int TA_FIRST   = 46;
    localparam int DATA_FIRST = 48;

    localparam logic [1:0] ST_SHORT = 2'b01;
    localparam logic [1:0] ST_EXT   = 2'b00;
    localparam logic [1:0] TA_DRV   = 2'b10;

    function automatic logic [FRAME_BITS-1:0] make_frame(
        input logic [1:0]  st,
        input logic [1:0]  op,
        input logic [4:0]  phy,
        input logic [4:0]  fld,
        input logic [15:0] payload
    );
        return {32'hFFFF_FFFF, st, op, phy, fld, TA_DRV, payload};
    endfunction
endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
    parameter int HALF_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half_len,
    output logic              mdc,
    output logic              rise_ev,
    output logic              fall_ev
);
    typedef struct packed {
        logic [HALF_W-1:0] cnt;
        logic              clk_lvl;
    } div_t;

    div_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        rise_ev = 1'b0;
        fall_ev = 1'b0;
        if (!run) begin
            st_d.cnt     = '0;
            st_d.clk_lvl = 1'b0;
        end else if (st_q.cnt == half_len - HALF_W'(1)) begin
            st_d.cnt     = '0;
            st_d.clk_lvl = !st_q.clk_lvl;
            rise_ev      = !st_q.clk_lvl;
            fall_ev      = st_q.clk_lvl;
        end else begin
            st_d.cnt = st_q.cnt + HALF_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc = st_q.clk_lvl;
endmodule

// File: rtl/mdio_frame_eng.sv
module mdio_frame_eng
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame_a,
    input  logic [FRAME_BITS-1:0] frame_b,
    input  logic                  two_frames,
    input  logic                  is_read,
    input  logic                  rise_ev,
    input  logic                  fall_ev,
    input  logic                  mdio_i,
    output logic                  active,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic                  done,
    output logic [15:0]           rdata
);
    localparam int CNT_W = $clog2(FRAME_BITS);

    typedef struct packed {
        logic                  busy;
        logic                  two;
        logic                  second;
        logic                  rd;
        logic [CNT_W-1:0]      cnt;
        logic [FRAME_BITS-1:0] sh;
        logic [FRAME_BITS-1:0] pend;
        logic [15:0]           cap;
    } eng_t;

    eng_t st_d, st_q;
    logic last_frame;
    logic released;

    assign last_frame = !st_q.two || st_q.second;
    assign released   = st_q.rd && last_frame && (st_q.cnt >= CNT_W'(TA_FIRST));

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (start) begin
            st_d.busy   = 1'b1;
            st_d.two    = two_frames;
            st_d.second = 1'b0;
            st_d.rd     = is_read;
            st_d.cnt    = '0;
            st_d.sh     = frame_a;
            st_d.pend   = frame_b;
            st_d.cap    = '0;
        end else if (st_q.busy) begin
            if (rise_ev && st_q.rd && last_frame && st_q.cnt >= CNT_W'(DATA_FIRST))
                st_d.cap = {st_q.cap[14:0], mdio_i};
            if (fall_ev) begin
                if (st_q.cnt == CNT_W'(FRAME_BITS - 1)) begin
                    if (!last_frame) begin
                        st_d.sh     = st_q.pend;
                        st_d.cnt    = '0;
                        st_d.second = 1'b1;
                    end else begin
                        st_d.busy = 1'b0;
                        done      = 1'b1;
                    end
                end else begin
                    st_d.sh  = {st_q.sh[FRAME_BITS-2:0], 1'b0};
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign active  = st_q.busy;
    assign mdio_o  = st_q.busy & st_q.sh[FRAME_BITS-1];
    assign mdio_oe = st_q.busy & !released;
    assign rdata   = st_q.cap;
endmodule

// File: rtl/mdio_mgmt.sv
module mdio_mgmt
    import mdio_pkg::*;
#(
    parameter int CR_W = 3,
    parameter int STEP = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        wr_sel,
    input  logic [31:0] wr_data,
    input  logic        rd_sel,
    output logic [31:0] rd_data,
    output logic        mdc,
    input  logic        mdio_i,
    output logic        mdio_o,
    output logic        mdio_oe
);
    localparam int CR_LSB  = 4;
    localparam int FLD_LSB = 8;
    localparam int PHY_LSB = 16;
    localparam int HALF_W  = CR_W + $clog2(STEP) + 1;

    typedef struct packed {
        logic            busy;
        logic            ext;
        logic [1:0]      op;
        logic [CR_W-1:0] cr;
        logic [4:0]      fld;
        logic [4:0]      phy;
        logic [31:0]     data;
    } reg_t;

    reg_t st_d, st_q;

    logic                  start;
    logic                  done;
    logic                  active;
    logic                  rise_ev, fall_ev;
    logic [15:0]           rdata;
    logic [HALF_W-1:0]     half_len;
    logic [FRAME_BITS-1:0] frame_a, frame_b;
    logic [31:0]           cmd_view;

    logic       w_ext, w_rd;
    logic [4:0] w_phy, w_fld;

    assign w_ext = wr_data[1];
    assign w_rd  = wr_data[3];
    assign w_phy = wr_data[PHY_LSB +: 5];
    assign w_fld = wr_data[FLD_LSB +: 5];

    always_comb begin
        if (w_ext) begin
            frame_a = make_frame(ST_EXT, 2'b00, w_phy, w_fld, st_q.data[31:16]);
        end else begin
            frame_a = make_frame(ST_SHORT, w_rd ? 2'b10 : 2'b01, w_phy, w_fld,
                                 st_q.data[15:0]);
        end
        frame_b = make_frame(ST_EXT, w_rd ? 2'b11 : 2'b01, w_phy, w_fld, st_q.data[15:0]);
    end

    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        if (wr_en && !st_q.busy) begin
            if (!wr_sel) begin
                st_d.ext  = w_ext;
                st_d.op   = wr_data[3:2];
                st_d.cr   = wr_data[CR_LSB +: CR_W];
                st_d.fld  = w_fld;
                st_d.phy  = w_phy;
                st_d.busy = wr_data[0];
                start     = wr_data[0];
            end else begin
                st_d.data = wr_data;
            end
        end
        if (done) begin
            st_d.busy = 1'b0;
            if (st_q.op[1]) st_d.data[15:0] = rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign half_len = HALF_W'((32'(st_q.cr) + 32'd1) * STEP);

    always_comb begin
        cmd_view                     = '0;
        cmd_view[0]                  = st_q.busy;
        cmd_view[1]                  = st_q.ext;
        cmd_view[3:2]                = st_q.op;
        cmd_view[CR_LSB +: CR_W]     = st_q.cr;
        cmd_view[FLD_LSB +: 5]       = st_q.fld;
        cmd_view[PHY_LSB +: 5]       = st_q.phy;
    end

    assign rd_data = rd_sel ? st_q.data : cmd_view;

    mdio_mdc_div #(.HALF_W(HALF_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (active),
        .half_len (half_len),
        .mdc      (mdc),
        .rise_ev  (rise_ev),
        .fall_ev  (fall_ev)
    );

    mdio_frame_eng u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .frame_a    (frame_a),
        .frame_b    (frame_b),
        .two_frames (w_ext),
        .is_read    (w_rd),
        .rise_ev    (rise_ev),
        .fall_ev    (fall_ev),
        .mdio_i     (mdio_i),
        .active     (active),
        .mdio_o     (mdio_o),
        .mdio_oe    (mdio_oe),
        .done       (done),
        .rdata      (rdata)
    );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        wr_sel,
    input logic [31:0] wr_data,
    input logic [31:0] cmd_view,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    // R1
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_sel && wr_data[0] && !cmd_view[0]) |=> cmd_view[0]);

    // R4
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_view[0] |-> !mdc);

    // R5
    oe_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_view[0] |-> !mdio_oe);

    // R7
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_view[0] && $past(cmd_view[0])) |-> $stable(cmd_view[20:1]));

    // R2
    data_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && mdc && $past(mdc)) |-> $stable(mdio_o));
endmodule

bind mdio_mgmt mdio_mgmt_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .cmd_view (cmd_view),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe)
);

// File: tb/sim_mdio_mgmt.sv
`timescale 1ns/100ps
module sim_mdio_mgmt;
    localparam logic [31:0] CMD_MASK = 32'h001F_1F7E;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int vectors = 0;
    int mism = 0;
    int cyc = 0;
    bit run_chk = 0;

    bit          expb [0:127];
    bit          m_act = 0, m_read = 0, m_ext = 0;
    int          m_H = 1, m_S = 0, m_total = 0, m_nbits = 64;
    logic [15:0] m_rv = '0;
    logic [31:0] sh_cmd = '0, sh_data = '0;

    mdio_mgmt u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .mdc(mdc), .mdio_i(mdio_i),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc++;

    function automatic void chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            mism++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endfunction

    task automatic arm(input logic [31:0] c);
        logic [63:0] fa, fb;
        logic [4:0]  p, r;
        p = c[20:16];
        r = c[12:8];
        m_read = c[3];
        m_ext = c[1];
        if (m_ext) begin
            fa = {32'hFFFF_FFFF, 2'b00, 2'b00, p, r, 2'b10, sh_data[31:16]};
            fb = {32'hFFFF_FFFF, 2'b00, m_read ? 2'b11 : 2'b01, p, r, 2'b10, sh_data[15:0]};
            m_nbits = 128;
        end else begin
            fa = {32'hFFFF_FFFF, 2'b01, m_read ? 2'b10 : 2'b01, p, r, 2'b10, sh_data[15:0]};
            fb = '0;
            m_nbits = 64;
        end
        for (int i = 0; i < 64; i++) begin
            expb[i] = fa[63-i];
            expb[64+i] = fb[63-i];
        end
        m_H = int'(c[6:4]) + 1;
        m_total = m_nbits * 2 * m_H;
        m_S = cyc + 1;
        m_act = 1;
    endtask

    always @(negedge clk) begin : model
        int t, idx, loc;
        bit last, e_oe;
        if (run_chk) begin
            t = cyc - m_S;
            if (m_act && t >= 0 && t < m_total) begin
                idx = t / (2 * m_H);
                loc = idx % 64;
                last = idx >= m_nbits - 64;
                e_oe = !(m_read && last && loc >= 46);
                chk("R4 mdc", {31'b0, mdc}, {31'b0, 1'((t / m_H) % 2)});
                chk("R5 oe", {31'b0, mdio_oe}, {31'b0, e_oe});
                if (e_oe) chk(m_ext ? "R3 bit" : "R2 bit", {31'b0, mdio_o}, {31'b0, expb[idx]});
                chk("R1 busy", {31'b0, rd_data[0]}, 32'd1);
                mdio_i = (m_read && last && loc >= 48) ? m_rv[63-loc] : 1'b1;
            end else begin
                if (m_act && t >= m_total) begin
                    m_act = 0;
                    if (m_read) sh_data[15:0] = m_rv;
                end
                chk("R4 mdc idle", {31'b0, mdc}, 32'd0);
                chk("R5 oe idle", {31'b0, mdio_oe}, 32'd0);
                chk("R1 busy idle", {31'b0, rd_data[0]}, 32'd0);
                mdio_i = 1'b1;
            end
        end
    end

    task automatic wr(input bit s, input logic [31:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_sel = s;
        wr_data = v;
        if (!m_act) begin
            if (s) sh_data = v;
            else begin
                sh_cmd = v & CMD_MASK;
                if (v[0]) arm(v);
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rb(input bit s, input logic [31:0] exp, input string req);
        @(posedge clk);
        #0.5 rd_sel = s;
        #0.5 chk(req, rd_data, exp);
        rd_sel = 1'b0;
    endtask

    task automatic wait_done();
        while (m_act) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        mism++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, mism);
        $finish;
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        rb(0, 32'h0, "R8 reset cmd");
        rb(1, 32'h0, "R8 reset data");
        run_chk = 1;

        // R8: fields only, no start
        wr(0, 32'h0005_0324);
        repeat (10) @(negedge clk);
        rb(0, 32'h0005_0324, "R8 fields stored");

        // R2: short write, fastest clock
        wr(1, 32'h1357_A5C3);
        wr(0, 32'h0003_1105);
        wait_done();
        rb(0, 32'h0003_1104, "R1 busy cleared");

        // R5: short read, CR=1
        m_rv = 16'hBEEF;
        wr(0, 32'h001E_0A1D);
        wait_done();
        rb(1, 32'h1357_BEEF, "R5 read data");

        // R6: code 00 writes, code 10 reads
        wr(1, 32'h0000_6C39);
        wr(0, 32'h0009_0201);
        wait_done();
        m_rv = 16'h1234;
        wr(0, 32'h0011_1F29);
        wait_done();
        rb(1, 32'h0000_1234, "R6 code 10 reads");

        // R3: extended write, CR=3
        wr(1, 32'h8001_5A5A);
        wr(0, 32'h0002_0737);
        wait_done();
        rb(1, 32'h8001_5A5A, "R3 write keeps data");

        // R3: extended read
        m_rv = 16'hC0DE;
        wr(1, 32'h4242_0000);
        wr(0, 32'h001F_1F0F);
        wait_done();
        rb(1, 32'h4242_C0DE, "R3 read data");

        // R7: writes while busy are ignored
        m_rv = 16'h0F0F;
        wr(1, 32'h7777_0000);
        wr(0, 32'h0004_0C1D);
        repeat (20) @(negedge clk);
        wr(0, 32'h001B_0303);
        wr(1, 32'hFFFF_FFFF);
        wait_done();
        rb(0, 32'h0004_0C1C, "R7 cmd unchanged");
        rb(1, 32'h7777_0F0F, "R7 data unchanged");
        repeat (10) @(negedge clk);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, mism);
        $finish;
    end
endmodule